// File: doc/BRIEF.md
# Banked Core Register File

This block holds the architectural integer state of a small load/store microcontroller core: sixteen 32-bit registers addressed by a 4-bit index. Indices 0 to 12 are plain general-purpose registers that hold data or addresses. Index 13 is the stack pointer, index 14 the link register, and index 15 the program counter, which holds the address of the next instruction to fetch. Two combinational read ports serve the operand fetch, and one write port commits results at the clock edge.

The stack pointer is not one register but two: a main stack pointer and a process stack pointer. Index 13 reaches exactly one of them at any time. In handler mode it is always the main one. In thread mode a control bit can switch it to the process one. Dedicated call and return strobes move return addresses between the link register and the program counter without using the general write port. A packed status word combines condition flags, execution state and the active interrupt number for the rest of the core.

Top module: `cpu_regbank`

## Requirements
- R1: A write with `wr_en` high to any index 0..12 stores `wr_data` at the clock edge, and both read ports return that value for that index afterwards.
- R2: Reads are combinational from stored state with no bypass: a read of the index being written in the same cycle returns the old value, and the new value appears after the edge.
- R3: After reset every register reads zero, `branch_valid` is low and the process-stack select is cleared, so index 13 reaches the main stack pointer in both modes.
- R4: While `handler_mode` is 1, index 13 reads and writes the main stack pointer whatever the select bit holds.
- R5: A cycle with `ctrl_we` high loads `ctrl_psp_sel` into the select bit. While `handler_mode` is 0, a select of 1 makes index 13 reach the process stack pointer and 0 makes it reach the main one.
- R6: Bits 1:0 of both stack pointers always read 0; those bits of any write to index 13 are dropped.
- R7: `call_stb` loads `call_addr` into index 14 at the edge and wins over a general write to index 14 in the same cycle.
- R8: `ret_stb` loads the value index 14 held before the edge, with bit 0 cleared, into index 15. It wins over a general write to index 15, and a call in the same cycle does not change the value returned.
- R9: A general write to index 15 stores `wr_data` with bit 0 cleared. That write or a return raises `branch_valid` for exactly the one cycle after the edge, with `branch_target` equal to the new index 15 value.
- R10: `psr_out` carries `flags_in` in bits 31:28, `exec_state_in` in bit 24, `irq_num_in` in bits 8:0, and zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| handler_mode | input | 1 | 1 = handler mode, 0 = thread mode |
| ctrl_we | input | 1 | Load the stack select bit |
| ctrl_psp_sel | input | 1 | New select value, 1 = process stack in thread mode |
| rd_addr_a | input | 4 | Read port A index |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 4 | Read port B index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 4 | General write index |
| wr_data | input | 32 | General write data |
| call_stb | input | 1 | Store return address in index 14 |
| call_addr | input | 32 | Return address for a call |
| ret_stb | input | 1 | Copy index 14 into index 15 |
| branch_valid | output | 1 | One-cycle pulse after a PC change |
| branch_target | output | 32 | New PC value during the pulse |
| flags_in | input | 4 | Condition flags view |
| exec_state_in | input | 1 | Execution state view |
| irq_num_in | input | 9 | Active interrupt number view |
| psr_out | output | 32 | Packed status word |

## Verification
The hardest state to reach is one where the two stack pointers hold different values while the mode and select bit change under them, because only then does a wrong bank choice show at the read port. The stimulus loads distinct values into each pointer through index 13, once in thread mode with the select set and once in handler mode, then reads index 13 under each mode and select combination. Conflicts between strobes and the general write port come from driving call, return and a general write to indices 14 or 15 in the same cycle.

// File: rtl/rb_pkg.sv
package rb_pkg;

    parameter int unsigned RB_XLEN   = 32;
    parameter int unsigned RB_IDX_W  = 4;
    parameter int unsigned RB_GPRS   = 13;

    typedef enum logic {
        SP_MAIN = 1'b0,
        SP_PROC = 1'b1
    } sp_bank_e;

endpackage

// File: rtl/rb_sp_select.sv
module rb_sp_select
    import rb_pkg::*;
(
    input  logic     handler_mode,
    input  logic     psp_sel,
    output sp_bank_e bank
);

    always_comb begin
        if (handler_mode) begin
            bank = SP_MAIN;
        end else if (psp_sel) begin
            bank = SP_PROC;
        end else begin
            bank = SP_MAIN;
        end
    end

endmodule

// File: rtl/rb_read_port.sv
module rb_read_port #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned NUM_GPR = 13
) (
    input  logic [IDX_W-1:0]               addr,
    input  logic [NUM_GPR-1:0][DATA_W-1:0] gpr,
    input  logic [DATA_W-1:0]              sp_active,
    input  logic [DATA_W-1:0]              lr,
    input  logic [DATA_W-1:0]              pc,
    output logic [DATA_W-1:0]              data
);

    localparam logic [IDX_W-1:0] IDX_SP = IDX_W'(NUM_GPR);
    localparam logic [IDX_W-1:0] IDX_LR = IDX_W'(NUM_GPR + 1);

    always_comb begin
        if (addr < IDX_SP) begin
            data = gpr[addr];
        end else if (addr == IDX_SP) begin
            data = sp_active;
        end else if (addr == IDX_LR) begin
            data = lr;
        end else begin
            data = pc;
        end
    end

endmodule

// File: rtl/rb_psr_pack.sv
module rb_psr_pack #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned FLAG_W   = 4,
    parameter int unsigned EXEC_BIT = 24,
    parameter int unsigned IRQ_W    = 9
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic              exec_state,
    input  logic [IRQ_W-1:0]  irq_num,
    output logic [DATA_W-1:0] psr
);

    always_comb begin
        psr                         = '0;
        psr[DATA_W-1 -: FLAG_W]     = flags;
        psr[EXEC_BIT]               = exec_state;
        psr[IRQ_W-1:0]              = irq_num;
    end

endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
    import rb_pkg::*;
#(
    parameter int unsigned DATA_W   = RB_XLEN,
    parameter int unsigned IDX_W    = RB_IDX_W,
    parameter int unsigned NUM_GPR  = RB_GPRS,
    parameter int unsigned FLAG_W   = 4,
    parameter int unsigned EXEC_BIT = 24,
    parameter int unsigned IRQ_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              handler_mode,
    input  logic              ctrl_we,
    input  logic              ctrl_psp_sel,
    input  logic [IDX_W-1:0]  rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [IDX_W-1:0]  rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              call_stb,
    input  logic [DATA_W-1:0] call_addr,
    input  logic              ret_stb,
    output logic              branch_valid,
    output logic [DATA_W-1:0] branch_target,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic              exec_state_in,
    input  logic [IRQ_W-1:0]  irq_num_in,
    output logic [DATA_W-1:0] psr_out
);

    localparam int unsigned      NUM_RD = 2;
    localparam logic [IDX_W-1:0] IDX_SP = IDX_W'(NUM_GPR);
    localparam logic [IDX_W-1:0] IDX_LR = IDX_W'(NUM_GPR + 1);
    localparam logic [IDX_W-1:0] IDX_PC = IDX_W'(NUM_GPR + 2);

    typedef struct packed {
        logic [NUM_GPR-1:0][DATA_W-1:0] gpr;
        logic [DATA_W-1:0]              msp;
        logic [DATA_W-1:0]              psp;
        logic [DATA_W-1:0]              lr;
        logic [DATA_W-1:0]              pc;
        logic                           psp_sel;
        logic                           br_valid;
        logic [DATA_W-1:0]              br_target;
    } state_t;

    state_t   st_d, st_q;
    sp_bank_e bank;

    logic [DATA_W-1:0] msp_q, psp_q, lr_q, pc_q, sp_active;
    logic [IDX_W-1:0]  rd_addr_arr [NUM_RD];
    logic [DATA_W-1:0] rd_data_arr [NUM_RD];

    assign msp_q = st_q.msp;
    assign psp_q = st_q.psp;
    assign lr_q  = st_q.lr;
    assign pc_q  = st_q.pc;

    rb_sp_select u_sp_sel (
        .handler_mode (handler_mode),
        .psp_sel      (st_q.psp_sel),
        .bank         (bank)
    );

    assign sp_active = (bank == SP_PROC) ? psp_q : msp_q;

    // Next-state computation for the whole bank
    always_comb begin
        st_d          = st_q;
        st_d.br_valid = 1'b0;

        if (ctrl_we) begin
            st_d.psp_sel = ctrl_psp_sel;
        end

        if (wr_en) begin
            if (wr_addr < IDX_SP) begin
                st_d.gpr[wr_addr] = wr_data;
            end else if (wr_addr == IDX_SP) begin
                if (bank == SP_PROC) begin
                    st_d.psp = {wr_data[DATA_W-1:2], 2'b00};
                end else begin
                    st_d.msp = {wr_data[DATA_W-1:2], 2'b00};
                end
            end else if (wr_addr == IDX_LR) begin
                st_d.lr = wr_data;
            end else if (wr_addr == IDX_PC) begin
                st_d.pc        = {wr_data[DATA_W-1:1], 1'b0};
                st_d.br_valid  = 1'b1;
                st_d.br_target = {wr_data[DATA_W-1:1], 1'b0};
            end
        end

        // Strobes override the general write port
        if (call_stb) begin
            st_d.lr = call_addr;
        end

        if (ret_stb) begin
            st_d.pc        = {st_q.lr[DATA_W-1:1], 1'b0};
            st_d.br_valid  = 1'b1;
            st_d.br_target = {st_q.lr[DATA_W-1:1], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr_arr[0] = rd_addr_a;
    assign rd_addr_arr[1] = rd_addr_b;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rb_read_port #(
            .DATA_W  (DATA_W),
            .IDX_W   (IDX_W),
            .NUM_GPR (NUM_GPR)
        ) u_rp (
            .addr      (rd_addr_arr[p]),
            .gpr       (st_q.gpr),
            .sp_active (sp_active),
            .lr        (lr_q),
            .pc        (pc_q),
            .data      (rd_data_arr[p])
        );
    end

    assign rd_data_a     = rd_data_arr[0];
    assign rd_data_b     = rd_data_arr[1];
    assign branch_valid  = st_q.br_valid;
    assign branch_target = st_q.br_target;

    rb_psr_pack #(
        .DATA_W   (DATA_W),
        .FLAG_W   (FLAG_W),
        .EXEC_BIT (EXEC_BIT),
        .IRQ_W    (IRQ_W)
    ) u_psr (
        .flags      (flags_in),
        .exec_state (exec_state_in),
        .irq_num    (irq_num_in),
        .psr        (psr_out)
    );

endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              handler_mode,
    input logic [IDX_W-1:0]  rd_addr_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_addr,
    input logic              call_stb,
    input logic [DATA_W-1:0] call_addr,
    input logic              ret_stb,
    input logic              branch_valid,
    input logic [DATA_W-1:0] branch_target,
    input logic [DATA_W-1:0] sp_main,
    input logic [DATA_W-1:0] sp_proc,
    input logic [DATA_W-1:0] lr,
    input logic [DATA_W-1:0] pc
);

    localparam logic [IDX_W-1:0] IDX_SP = IDX_W'(13);
    localparam logic [IDX_W-1:0] IDX_PC = IDX_W'(15);

    a_r4_handler_reads_main: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_mode && rd_addr_a == IDX_SP) |-> (rd_data_a == sp_main));

    a_r6_sp_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (sp_main[1:0] == 2'b00 && sp_proc[1:0] == 2'b00));

    a_r7_call_fills_lr: assert property (@(posedge clk) disable iff (!rst_n)
        call_stb |=> (lr == $past(call_addr)));

    a_r8_ret_fills_pc: assert property (@(posedge clk) disable iff (!rst_n)
        ret_stb |=> (pc[DATA_W-1:1] == $past(lr[DATA_W-1:1]) && pc[0] == 1'b0));

    a_r9_branch_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_addr == IDX_PC) && !ret_stb) |=> !branch_valid);

    a_r9_target_matches_pc: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |-> (branch_target == pc));

endmodule

bind cpu_regbank rb_checker #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_rb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .handler_mode  (handler_mode),
    .rd_addr_a     (rd_addr_a),
    .rd_data_a     (rd_data_a),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .call_stb      (call_stb),
    .call_addr     (call_addr),
    .ret_stb       (ret_stb),
    .branch_valid  (branch_valid),
    .branch_target (branch_target),
    .sp_main       (msp_q),
    .sp_proc       (psp_q),
    .lr            (lr_q),
    .pc            (pc_q)
);

// File: tb/cpu_regbank_test.sv
`timescale 1ns/1ps
module cpu_regbank_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        handler_mode, ctrl_we, ctrl_psp_sel;
    logic [3:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic [31:0] rd_data_a, rd_data_b, wr_data, call_addr;
    logic        wr_en, call_stb, ret_stb, branch_valid;
    logic [31:0] branch_target, psr_out;
    logic [3:0]  flags_in;
    logic        exec_state_in;
    logic [8:0]  irq_num_in;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    cpu_regbank uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .handler_mode  (handler_mode),
        .ctrl_we       (ctrl_we),
        .ctrl_psp_sel  (ctrl_psp_sel),
        .rd_addr_a     (rd_addr_a),
        .rd_data_a     (rd_data_a),
        .rd_addr_b     (rd_addr_b),
        .rd_data_b     (rd_data_b),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .call_stb      (call_stb),
        .call_addr     (call_addr),
        .ret_stb       (ret_stb),
        .branch_valid  (branch_valid),
        .branch_target (branch_target),
        .flags_in      (flags_in),
        .exec_state_in (exec_state_in),
        .irq_num_in    (irq_num_in),
        .psr_out       (psr_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // One-cycle general write, returns at the following negedge
    task automatic gwrite(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_sel(input logic s);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_psp_sel = s;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic read_a(input logic [3:0] a, output logic [31:0] d);
        rd_addr_a = a;
        #1;
        d = rd_data_a;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) begin
            read_a(4'(i), v);
            check("R3 reset value", v, 32'h0);
        end
        check("R3 branch_valid low", {31'h0, branch_valid}, 32'h0);
        handler_mode = 1'b0;
        gwrite(4'd13, 32'h0000_0100);
        handler_mode = 1'b1;
        read_a(4'd13, v);
        check("R3 main stack active after reset", v, 32'h0000_0100);
        handler_mode = 1'b0;
    endtask

    task automatic t_gpr();
        logic [31:0] v;
        for (int i = 0; i < 13; i++) begin
            gwrite(4'(i), 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0011));
        end
        for (int i = 0; i < 13; i++) begin
            rd_addr_a = 4'(i);
            rd_addr_b = 4'(12 - i);
            #1;
            check("R1 port A", rd_data_a, 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0011));
            check("R1 port B", rd_data_b, 32'hA5A5_0000 ^ (32'(12 - i) * 32'h0101_0011));
        end
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        rd_addr_a = 4'd5; rd_addr_b = 4'd5;
        wr_en = 1'b1; wr_addr = 4'd5; wr_data = 32'hDEAD_BEEF;
        #1;
        check("R2 old value during write", rd_data_a, 32'hA5A5_0000 ^ (32'd5 * 32'h0101_0011));
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R2 new value after edge", rd_data_b, 32'hDEAD_BEEF);
    endtask

    task automatic t_stack_bank();
        logic [31:0] v;
        handler_mode = 1'b0;
        set_sel(1'b1);
        read_a(4'd13, v);
        check("R5 thread select reaches process stack", v, 32'h0);
        gwrite(4'd13, 32'h2000_0007);
        read_a(4'd13, v);
        check("R6 process stack low bits dropped", v, 32'h2000_0004);
        handler_mode = 1'b1;
        read_a(4'd13, v);
        check("R4 handler reads main stack", v, 32'h0000_0100);
        gwrite(4'd13, 32'h1000_00FF);
        read_a(4'd13, v);
        check("R6 main stack low bits dropped", v, 32'h1000_00FC);
        handler_mode = 1'b0;
        read_a(4'd13, v);
        check("R4 handler write left process stack", v, 32'h2000_0004);
        set_sel(1'b0);
        read_a(4'd13, v);
        check("R5 thread select clear reaches main", v, 32'h1000_00FC);
    endtask

    task automatic t_call_ret();
        logic [31:0] v;
        @(negedge clk);
        call_stb = 1'b1; call_addr = 32'h0000_4321;
        wr_en = 1'b1; wr_addr = 4'd14; wr_data = 32'h1111_1111;
        @(negedge clk);
        call_stb = 1'b0; wr_en = 1'b0;
        read_a(4'd14, v);
        check("R7 call beats general write", v, 32'h0000_4321);
        @(negedge clk);
        ret_stb = 1'b1; call_stb = 1'b1; call_addr = 32'h0000_9999;
        wr_en = 1'b1; wr_addr = 4'd15; wr_data = 32'h7777_0000;
        @(negedge clk);
        ret_stb = 1'b0; call_stb = 1'b0; wr_en = 1'b0;
        read_a(4'd15, v);
        check("R8 return uses old link value", v, 32'h0000_4320);
        check("R9 return raises branch_valid", {31'h0, branch_valid}, 32'h1);
        check("R9 return target", branch_target, 32'h0000_4320);
        read_a(4'd14, v);
        check("R7 same-cycle call stored", v, 32'h0000_9999);
        @(negedge clk);
        check("R9 pulse lasts one cycle", {31'h0, branch_valid}, 32'h0);
    endtask

    task automatic t_branch();
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd15; wr_data = 32'h0800_1235;
        #1;
        check("R9 no pulse before edge", {31'h0, branch_valid}, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 pulse after PC write", {31'h0, branch_valid}, 32'h1);
        check("R9 target bit0 cleared", branch_target, 32'h0800_1234);
        read_a(4'd15, v);
        check("R9 PC holds cleared value", v, 32'h0800_1234);
        @(negedge clk);
        check("R9 pulse ends", {31'h0, branch_valid}, 32'h0);
    endtask

    task automatic t_psr();
        flags_in = 4'b1010; exec_state_in = 1'b1; irq_num_in = 9'h1A5;
        #1;
        check("R10 packed status", psr_out, 32'hA100_01A5);
        flags_in = 4'b0101; exec_state_in = 1'b0; irq_num_in = 9'h000;
        #1;
        check("R10 packed status second", psr_out, 32'h5000_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        handler_mode = 1'b0; ctrl_we = 1'b0; ctrl_psp_sel = 1'b0;
        rd_addr_a = '0; rd_addr_b = '0; wr_addr = '0; wr_data = '0; wr_en = 1'b0;
        call_stb = 1'b0; call_addr = '0; ret_stb = 1'b0;
        flags_in = '0; exec_state_in = 1'b0; irq_num_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gpr();
        t_same_cycle();
        t_stack_bank();
        t_call_ret();
        t_branch();
        t_psr();
        finish_run();
    end

endmodule